// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is an SPI slave that takes fixed 16-bit frames from a host controller and turns each one into a 4-bit opcode and a 12-bit operand. The serial clock idles low, and the slave samples the data line on the rising SCK edge. The host changes the data line on the falling edge. Each frame is framed by its own chip-select assertion. The bit count and the shift register start again whenever chip select goes low. The frame is accepted only when chip select is released after exactly 16 rising SCK edges.

SCK, MOSI and the active-low chip select pass through two-flop synchronizers into the system clock domain, and all edge detection is done there. For this reason the system clock must run at least four times faster than SCK. When a frame is accepted, the block pulses `frame_vld` and presents the opcode and operand. If the opcode equals the configuration opcode (parameter `CFG_OP`, default 4'h1), the low byte of the operand is written into a persistent mode register. For any other opcode, the block raises `cmd_stb` one cycle later so that downstream logic can act on the command.

Top module: `spi_cmd_rx`

## Requirements
- R1: After a synchronous reset, `mode_q` is 0 and both `frame_vld` and `cmd_stb` are low.
- R2: Bits are shifted in MSB first, on rising SCK edges while `cs_n` is low. For an accepted frame, `frame_op` holds frame bits 15..12 and `frame_arg` holds bits 11..0.
- R3: Every accepted frame produces exactly one `frame_vld` pulse, one system clock long, whatever its opcode. `frame_op` and `frame_arg` keep their values until the next accepted frame.
- R4: A frame with opcode `CFG_OP` (4'h1) loads `mode_q` with `frame_arg[7:0]`, one cycle after `frame_vld`. Operand bits 11..8 have no effect, and no `cmd_stb` is raised.
- R5: A frame with any other opcode raises `cmd_stb` for exactly one cycle, in the cycle after `frame_vld`, and leaves `mode_q` unchanged.
- R6: A frame that ends with fewer than 16 SCK rising edges is discarded. This includes a chip-select pulse with no edges at all. No pulse is raised and `mode_q` is unchanged.
- R7: A frame that ends with more than 16 SCK rising edges is discarded in the same way.
- R8: SCK edges that occur while `cs_n` is high are ignored, so the next framed transfer decodes normally.
- R9: `mode_q` keeps its value across all non-configuration and discarded frames, until the next accepted configuration frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Raw serial clock from the host, idles low |
| mosi | input | 1 | Raw serial data from the host |
| cs_n | input | 1 | Raw active-low chip select |
| mode_q | output | 8 | Mode register |
| frame_vld | output | 1 | One-cycle pulse for each accepted frame |
| frame_op | output | 4 | Opcode of the last accepted frame |
| frame_arg | output | 12 | Operand of the last accepted frame |
| cmd_stb | output | 1 | One-cycle pulse for an accepted non-configuration frame |

## Verification
The hardest situations to reach are the frames that must be rejected: a transfer one bit short, a transfer one bit long, and a chip-select pulse with no clock edges. In each case nothing may change at the ports. The stimulus table mixes these malformed lengths between valid frames, so a wrongly accepted frame would show up as an extra pulse or a changed mode register. A directed test then toggles SCK with chip select released before sending a valid frame. This shows that stray edges do not leak into the bit count.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int OP_W    = 4;
  localparam int ARG_W   = 12;
  localparam int FRAME_W = OP_W + ARG_W;
  localparam int MODE_W  = 8;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [ARG_W-1:0] arg;
  } cmd_word_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= din;
      else chain[s] <= chain[(s > 0) ? s-1 : 0];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_s,
  input  logic               mosi_s,
  input  logic               csn_s,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sck_d, csn_d;
  logic               sck_rise, csn_fall, csn_rise;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;

  assign sck_rise = sck_s & ~sck_d;
  assign csn_fall = ~csn_s & csn_d;
  assign csn_rise = csn_s & ~csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= 1'b0;
      csn_d      <= 1'b1;
      bit_cnt    <= CNT_OVER;
      shreg      <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      sck_d     <= sck_s;
      csn_d     <= csn_s;
      frame_vld <= 1'b0;
      if (csn_fall) begin
        bit_cnt <= '0;
      end else if (!csn_s && sck_rise) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_s};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
      if (csn_rise && bit_cnt == CNT_FULL) begin
        frame_vld  <= 1'b1;
        frame_word <= shreg;
      end
    end
  end

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld);

  // R6
  vld_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> csn_s);
endmodule

// File: rtl/spi_cmd_dec.sv
module spi_cmd_dec #(
  parameter int OP_W   = 4,
  parameter int ARG_W  = 12,
  parameter int MODE_W = 8,
  parameter logic [OP_W-1:0] CFG_OP = 4'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [OP_W-1:0]   op,
  input  logic [ARG_W-1:0]  arg,
  output logic [MODE_W-1:0] mode_q,
  output logic              cmd_stb
);
  logic is_cfg;
  assign is_cfg = (op == CFG_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      cmd_stb <= 1'b0;
    end else begin
      cmd_stb <= vld & ~is_cfg;
      if (vld && is_cfg) mode_q <= arg[MODE_W-1:0];
    end
  end

  // R4
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    (vld && op == CFG_OP) |=> mode_q == $past(arg[MODE_W-1:0]));

  // R5
  stb_src_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> ($past(vld) && $past(op) != CFG_OP));

  // R9
  mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(mode_q));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter logic [OP_W-1:0] CFG_OP  = 4'h1,
  parameter int              SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic [MODE_W-1:0] mode_q,
  output logic              frame_vld,
  output logic [OP_W-1:0]   frame_op,
  output logic [ARG_W-1:0]  frame_arg,
  output logic              cmd_stb
);
  logic [2:0] raw_in, sync_out;
  logic [FRAME_W-1:0] word;
  cmd_word_t cw;

  assign raw_in = {cs_n, mosi, sck};

  spi_cmd_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .din(raw_in), .dout(sync_out)
  );

  spi_cmd_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .sck_s(sync_out[0]), .mosi_s(sync_out[1]), .csn_s(sync_out[2]),
    .frame_vld(frame_vld), .frame_word(word)
  );

  assign cw        = cmd_word_t'(word);
  assign frame_op  = cw.op;
  assign frame_arg = cw.arg;

  spi_cmd_dec #(.OP_W(OP_W), .ARG_W(ARG_W), .MODE_W(MODE_W), .CFG_OP(CFG_OP)) u_dec (
    .clk(clk), .rst(rst), .vld(frame_vld), .op(frame_op), .arg(frame_arg),
    .mode_q(mode_q), .cmd_stb(cmd_stb)
  );
endmodule

// File: tb/spi_cmd_rx_bench.sv
module spi_cmd_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int NVEC       = 9;
  // {bit count, frame word}; opcode 4'h1 is the configuration opcode
  localparam logic [20:0] VEC [NVEC] = '{
    {5'd16, 16'h10A5},  // cfg, mode <= A5
    {5'd16, 16'h3123},  // command 3
    {5'd16, 16'h1F3C},  // cfg, upper operand bits ignored
    {5'd15, 16'h1055},  // short
    {5'd17, 16'h1077},  // long
    {5'd16, 16'h0FFF},  // command 0
    {5'd8,  16'h1099},  // short
    {5'd16, 16'hF000},  // command F
    {5'd0,  16'h1011}   // CS pulse only
  };

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic [7:0]  mode_q;
  logic        frame_vld, cmd_stb;
  logic [3:0]  frame_op;
  logic [11:0] frame_arg;

  int checks = 0, errors = 0;
  int vld_cnt = 0, stb_cnt = 0, wide_pulse = 0;
  logic prev_vld = 1'b0, prev_stb = 1'b0;
  logic [3:0]  cap_op = '0;
  logic [11:0] cap_arg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_cmd_rx u_spi_cmd_rx (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .mode_q(mode_q), .frame_vld(frame_vld), .frame_op(frame_op),
    .frame_arg(frame_arg), .cmd_stb(cmd_stb)
  );

  always @(negedge clk) begin
    if (frame_vld) begin
      vld_cnt <= vld_cnt + 1;
      cap_op  <= frame_op;
      cap_arg <= frame_arg;
    end
    if (cmd_stb) stb_cnt <= stb_cnt + 1;
    if ((frame_vld && prev_vld) || (cmd_stb && prev_stb)) wide_pulse <= wide_pulse + 1;
    prev_vld <= frame_vld;
    prev_stb <= cmd_stb;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    cs_n = 1'b0;
    clks(HALF_SCK);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15 - (i % 16)];
      clks(HALF_SCK);
      sck = 1'b1;
      clks(HALF_SCK);
      sck = 1'b0;
    end
    clks(HALF_SCK);
    cs_n = 1'b1;
    clks(12);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp_mode;
    int exp_vld, exp_stb;
    clks(4);
    rst = 1'b0;
    clks(2);
    // R1 reset state
    chk(mode_q == 8'h00, "R1 mode", mode_q, 0);
    chk(!frame_vld && !cmd_stb, "R1 pulses", {frame_vld, cmd_stb}, 0);

    exp_mode = 8'h00; exp_vld = 0; exp_stb = 0;
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] w;
      int nb;
      w  = VEC[v][15:0];
      nb = int'(VEC[v][20:16]);
      send(w, nb);
      if (nb == 16) begin
        exp_vld++;
        if (w[15:12] == 4'h1) exp_mode = w[7:0];
        else exp_stb++;
        // R2 field split, MSB first
        chk(cap_op == w[15:12], "R2 opcode", cap_op, w[15:12]);
        chk(cap_arg == w[11:0], "R2 operand", cap_arg, w[11:0]);
      end
      // R3 one valid per accepted frame; R6 R7 none for bad lengths
      chk(vld_cnt == exp_vld, (nb == 16) ? "R3 valid count" : (nb > 16 ? "R7 valid count" : "R6 valid count"), vld_cnt, exp_vld);
      // R5 strobe only for non-config opcodes
      chk(stb_cnt == exp_stb, "R5 strobe count", stb_cnt, exp_stb);
      // R4 mode load; R9 mode held otherwise
      chk(mode_q == exp_mode, (nb == 16 && w[15:12] == 4'h1) ? "R4 mode" : "R9 mode", mode_q, exp_mode);
    end
    chk(wide_pulse == 0, "R3 pulse width", wide_pulse, 0);

    // R8 stray SCK edges with CS released
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; clks(HALF_SCK); sck = 1'b0; clks(HALF_SCK);
    end
    chk(vld_cnt == exp_vld, "R8 no frame from stray edges", vld_cnt, exp_vld);
    send(16'h1E42, 16);
    chk(mode_q == 8'h42, "R8 mode after stray edges", mode_q, 8'h42);
    chk(vld_cnt == exp_vld + 1, "R8 valid count", vld_cnt, exp_vld + 1);

    // R1 reset clears mode register
    rst = 1'b1; clks(3); rst = 1'b0; clks(2);
    chk(mode_q == 8'h00, "R1 mode after reset", mode_q, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule